// File: doc/BRIEF.md
# Serial ADC Readout Master

This block is the host-side master for a 12-bit sampling converter that has a three-wire serial link: one active-low select per converter, a shared shift clock, and a shared data line from the converters to the host. The converter takes no command word, so the master never sends anything. It only times the select and clock lines and collects the returned bits. A start request with a device index opens a frame. The master lowers that device's select and produces a divided shift clock of exactly fourteen pulses. The first pulse only wakes the converter's output and the second pulse carries a dummy bit. The last twelve pulses carry the result, most significant bit first.

Data is taken on each rising shift-clock edge, half a period after the converter has updated its output on the falling edge. After the fourteenth falling edge the select returns high and the word is presented for one cycle together with the device index. A recovery counter then keeps every select high for a set number of system cycles. This gives the converter its sampling window before the next frame can begin. Several converters share the clock and data wires, and only the one whose select is low is clocked and read.

Top module: `adc_rd_master`

## Requirements
- R1: While reset is held, every select output is high, the shift clock is low, the valid strobe is low and busy is high. After reset is released, busy stays high for IDLE_CYC-1 sampled cycles before the first start can be taken.
- R2: A start taken while busy is low with a device index below NUM_DEV drives low only the select of that index, at the next clock edge. All other selects stay high.
- R3: The shift clock is low whenever every select is high. During a frame it makes exactly 14 pulses, and each high phase and each low phase lasts CLK_HALF system cycles. The first rising edge comes CLK_HALF cycles after the select falls.
- R4: The data line is sampled on shift-clock rising edges. The values at rising edges 1 and 2 (output enable and dummy bit) are discarded. The values at rising edges 3 to 14 form the result, with edge 3 giving bit 11 and edge 14 giving bit 0.
- R5: At the clock edge of the 14th falling shift-clock edge, the select returns high and the valid strobe goes high for exactly one cycle. The strobe carries the result word and the device index of the frame. The select is low for 28*CLK_HALF system cycles.
- R6: After each frame, busy stays high for IDLE_CYC sampled cycles, counting the valid cycle. No select can fall during that time.
- R7: A start that arrives while busy is high, whether mid-frame or during recovery, is ignored. It changes no select, and the current frame's result and index are unaffected.
- R8: A start whose device index is NUM_DEV or larger is ignored. All selects stay high and busy stays low.
- R9: At most one select output is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin a conversion frame |
| dev_sel_i | input | DEV_W | Index of the converter to read |
| sdo_i | input | 1 | Shared serial data from the converters |
| busy_o | output | 1 | High during a frame and during recovery |
| sclk_o | output | 1 | Shared shift clock, idles low |
| cs_n_o | output | NUM_DEV | Active-low select, one per converter |
| res_valid_o | output | 1 | One-cycle strobe for a finished result |
| res_data_o | output | 12 | Result word |
| res_dev_o | output | DEV_W | Device index of the result |

## Verification
The bench builds the block with CLK_HALF=2, IDLE_CYC=10 and NUM_DEV=3. With these values a whole frame is 56 cycles and recovery is ten cycles, so each pulse width, edge position and recovery length can be counted exactly. Three devices on a two-bit index leave index 3 unused, which makes the out-of-range select reachable. The converter model drives ones during the enable and dummy slots, so a wrong skip count or bit order shows up in the result word.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    localparam int RES_W        = 12;
    localparam int LEAD_PULSES  = 2;
    localparam int FRAME_PULSES = LEAD_PULSES + RES_W;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } sclk_evt_t;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/adc_rd_clkgen.sv
module adc_rd_clkgen
    import adc_rd_pkg::*;
#(
    parameter int CLK_HALF = 50
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    output logic      sclk_o,
    output sclk_evt_t evt_o
);
    localparam int CW = idx_width(CLK_HALF);

    logic [CW-1:0] cnt_q;
    logic          sclk_q;
    logic          wrap;

    always_comb begin
        wrap       = run && (cnt_q == CW'(CLK_HALF - 1));
        evt_o.rise = wrap && !sclk_q;
        evt_o.fall = wrap && sclk_q;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else if (wrap) begin
            cnt_q  <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign sclk_o = sclk_q;

endmodule

// File: rtl/adc_rd_shreg.sv
module adc_rd_shreg
    import adc_rd_pkg::*;
#(
    parameter int W    = RES_W,
    parameter int SKIP = LEAD_PULSES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         sample,
    input  logic         sdo,
    output logic [W-1:0] word_o
);
    localparam int SW = idx_width(SKIP + 1);

    logic [SW-1:0] skip_q;
    logic [W-1:0]  word_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            skip_q <= '0;
            word_q <= '0;
        end else if (sample) begin
            if (skip_q < SW'(SKIP)) begin
                skip_q <= skip_q + 1'b1;
            end else begin
                word_q <= {word_q[W-2:0], sdo};
            end
        end
    end

    assign word_o = word_q;

endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
    import adc_rd_pkg::*;
#(
    parameter int NUM_DEV  = 4,
    parameter int IDLE_CYC = 250,
    parameter int DEV_W    = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [DEV_W-1:0]   dev_sel,
    input  sclk_evt_t          evt,
    input  logic [RES_W-1:0]   word_in,
    output logic               run,
    output logic               clear,
    output logic               busy,
    output logic [NUM_DEV-1:0] cs_n,
    output logic               valid,
    output logic [RES_W-1:0]   data,
    output logic [DEV_W-1:0]   dev_out
);
    localparam int FW = idx_width(FRAME_PULSES);
    localparam int IW = idx_width(IDLE_CYC + 1);

    seq_state_e       state_q;
    logic [FW-1:0]    falls_q;
    logic [IW-1:0]    idle_q;
    logic [DEV_W-1:0] dev_q;
    logic [RES_W-1:0] data_q;
    logic             valid_q;
    logic             ready, sel_ok, accept, last_fall;

    always_comb begin
        ready     = (state_q == ST_IDLE) && (idle_q == IW'(IDLE_CYC));
        sel_ok    = ({1'b0, dev_sel} < (DEV_W + 1)'(NUM_DEV));
        accept    = start && ready && sel_ok;
        last_fall = (state_q == ST_SHIFT) && evt.fall &&
                    (falls_q == FW'(FRAME_PULSES - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            falls_q <= '0;
            idle_q  <= '0;
            dev_q   <= '0;
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (idle_q != IW'(IDLE_CYC)) idle_q <= idle_q + 1'b1;
                    if (accept) begin
                        state_q <= ST_SHIFT;
                        falls_q <= '0;
                        dev_q   <= dev_sel;
                    end
                end
                ST_SHIFT: begin
                    if (evt.fall) falls_q <= falls_q + 1'b1;
                    if (last_fall) begin
                        state_q <= ST_IDLE;
                        idle_q  <= '0;
                        valid_q <= 1'b1;
                        data_q  <= word_in;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    for (genvar i = 0; i < NUM_DEV; i++) begin : g_cs
        always_ff @(posedge clk) begin
            if (rst) begin
                cs_n[i] <= 1'b1;
            end else if (accept) begin
                cs_n[i] <= (dev_sel != DEV_W'(i));
            end else if (last_fall) begin
                cs_n[i] <= 1'b1;
            end
        end
    end

    assign run     = (state_q == ST_SHIFT);
    assign clear   = accept;
    assign busy    = !ready;
    assign valid   = valid_q;
    assign data    = data_q;
    assign dev_out = dev_q;

endmodule

// File: rtl/adc_rd_master.sv
module adc_rd_master
    import adc_rd_pkg::*;
#(
    parameter int NUM_DEV  = 4,
    parameter int CLK_HALF = 50,
    parameter int IDLE_CYC = 250,
    parameter int DEV_W    = idx_width(NUM_DEV)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [DEV_W-1:0]   dev_sel_i,
    input  logic               sdo_i,
    output logic               busy_o,
    output logic               sclk_o,
    output logic [NUM_DEV-1:0] cs_n_o,
    output logic               res_valid_o,
    output logic [RES_W-1:0]   res_data_o,
    output logic [DEV_W-1:0]   res_dev_o
);
    sclk_evt_t        evt;
    logic             run, clear;
    logic [RES_W-1:0] word;

    adc_rd_clkgen #(.CLK_HALF(CLK_HALF)) u_clk (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .sclk_o (sclk_o),
        .evt_o  (evt)
    );

    adc_rd_shreg #(.W(RES_W), .SKIP(LEAD_PULSES)) u_shr (
        .clk    (clk),
        .rst    (rst),
        .clear  (clear),
        .sample (evt.rise),
        .sdo    (sdo_i),
        .word_o (word)
    );

    adc_rd_seq #(.NUM_DEV(NUM_DEV), .IDLE_CYC(IDLE_CYC), .DEV_W(DEV_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start_i),
        .dev_sel (dev_sel_i),
        .evt     (evt),
        .word_in (word),
        .run     (run),
        .clear   (clear),
        .busy    (busy_o),
        .cs_n    (cs_n_o),
        .valid   (res_valid_o),
        .data    (res_data_o),
        .dev_out (res_dev_o)
    );

endmodule

// File: rtl/adc_rd_master_chk.sv
module adc_rd_master_chk
    import adc_rd_pkg::*;
#(
    parameter int NUM_DEV = 4,
    parameter int DEV_W   = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               start_i,
    input logic [DEV_W-1:0]   dev_sel_i,
    input logic               busy_o,
    input logic               sclk_o,
    input logic [NUM_DEV-1:0] cs_n_o,
    input logic               res_valid_o
);
    p_cs_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n_o));

    p_sclk_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (&cs_n_o) |-> !sclk_o);

    p_valid_single_r5: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |=> !res_valid_o);

    p_valid_cs_high_r5: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |-> (&cs_n_o));

    p_frame_busy_r6: assert property (@(posedge clk) disable iff (rst)
        !(&cs_n_o) |-> busy_o);

    p_ignore_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (busy_o && (&cs_n_o)) |=> (&cs_n_o));

    p_bad_sel_r8: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && ({1'b0, dev_sel_i} >= (DEV_W + 1)'(NUM_DEV)))
        |=> (&cs_n_o));

    p_sel_low_r2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && ({1'b0, dev_sel_i} < (DEV_W + 1)'(NUM_DEV)))
        |=> (cs_n_o[$past(dev_sel_i)] == 1'b0));

endmodule

bind adc_rd_master adc_rd_master_chk #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .dev_sel_i   (dev_sel_i),
    .busy_o      (busy_o),
    .sclk_o      (sclk_o),
    .cs_n_o      (cs_n_o),
    .res_valid_o (res_valid_o)
);

// File: tb/adc_rd_master_test.sv
module adc_rd_master_test;
    localparam int NDEV  = 3;
    localparam int HALF  = 2;
    localparam int IDLE  = 10;
    localparam int DW    = 2;
    localparam int NVEC  = 5;
    localparam logic [13:0] VEC [NVEC] = '{
        {2'd0, 12'hA5C}, {2'd1, 12'h000}, {2'd2, 12'hFFF},
        {2'd0, 12'h801}, {2'd2, 12'h3C3}
    };

    logic            clk = 1'b0, rst = 1'b1, start = 1'b0, sdo = 1'b1;
    logic [DW-1:0]   dev = '0;
    logic            busy, sclk, valid;
    logic [NDEV-1:0] cs_n;
    logic [11:0]     rdata;
    logic [DW-1:0]   rdev;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    logic [11:0] cur_word = '0;
    int lowcnt = 0, rises = 0, highs = 0, fall_n = 0, first_rise = -1;
    logic prev_sclk = 1'b0, prev_all = 1'b1;

    always #10 clk = ~clk;

    adc_rd_master #(.NUM_DEV(NDEV), .CLK_HALF(HALF), .IDLE_CYC(IDLE)) uut (
        .clk (clk), .rst (rst), .start_i (start), .dev_sel_i (dev),
        .sdo_i (sdo), .busy_o (busy), .sclk_o (sclk), .cs_n_o (cs_n),
        .res_valid_o (valid), .res_data_o (rdata), .res_dev_o (rdev)
    );

    // converter model and pulse counters, sampled on the falling system edge
    always @(negedge clk) begin
        if (!(&cs_n)) begin
            if (prev_all) begin
                lowcnt = 0; rises = 0; highs = 0; fall_n = 0; first_rise = -1;
            end
            if (sclk && !prev_sclk) begin
                if (rises == 0) first_rise = lowcnt;
                rises++;
            end
            if (sclk) highs++;
            if (!sclk && prev_sclk) begin
                fall_n++;
                if (fall_n >= 2 && fall_n <= 13) sdo = cur_word[13 - fall_n];
                else sdo = 1'b1;
            end
            lowcnt++;
        end else begin
            sdo = 1'b1;
        end
        prev_sclk = sclk;
        prev_all  = &cs_n;
    end

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_valid();
        while (!valid) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (5) @(negedge clk);
        check("R1 cs", int'(cs_n), 7);
        check("R1 sclk", int'(sclk), 0);
        check("R1 valid", int'(valid), 0);
        check("R1 busy", int'(busy), 1);
        rst = 1'b0;
        @(negedge clk);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        check("R1 busy after reset", n, IDLE - 1);

        for (int i = 0; i < NVEC; i++) begin
            logic [DW-1:0] d;
            d = VEC[i][13:12];
            cur_word = VEC[i][11:0];
            while (busy) @(negedge clk);
            start = 1'b1; dev = d;
            @(negedge clk);
            start = 1'b0;
            check("R2 select", int'(cs_n), int'(~(3'b1 << d) & 3'b111));
            if (i == 1) begin
                // R7: start during a frame for another device
                repeat (7) @(negedge clk);
                start = 1'b1; dev = 2'd2;
                @(negedge clk);
                start = 1'b0;
                check("R7 mid-frame cs", int'(cs_n), int'(~(3'b1 << d) & 3'b111));
            end
            wait_valid();
            check("R4 data", int'(rdata), int'(VEC[i][11:0]));
            check("R5 dev", int'(rdev), int'(d));
            check("R5 cs low span", lowcnt, 28 * HALF);
            check("R3 pulses", rises, 14);
            check("R3 first rise", first_rise, HALF);
            check("R3 high time", highs, 14 * HALF);
            n = 0;
            while (busy) begin
                n++;
                if (n == 1) check("R5 cs high at valid", int'(cs_n), 7);
                @(negedge clk);
                if (n == 1) check("R5 valid one cycle", int'(valid), 0);
            end
            check("R6 recovery", n, IDLE);
        end

        // R7: start during recovery is dropped
        cur_word = 12'h5A5;
        start = 1'b1; dev = 2'd1;
        @(negedge clk);
        start = 1'b0;
        wait_valid();
        check("R7 ref frame", int'(rdata), 12'h5A5);
        start = 1'b1; dev = 2'd2;
        @(negedge clk);
        start = 1'b0;
        check("R7 recovery cs", int'(cs_n), 7);
        while (busy) @(negedge clk);
        check("R7 cs after recovery", int'(cs_n), 7);
        check("R7 result kept", int'(rdata), 12'h5A5);

        // R8: out-of-range device index
        start = 1'b1; dev = 2'd3;
        @(negedge clk);
        start = 1'b0;
        check("R8 cs", int'(cs_n), 7);
        check("R8 busy", int'(busy), 0);
        repeat (3) @(negedge clk);
        check("R8 sclk", int'(sclk), 0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule